// File: doc/BRIEF.md
# GPIO Port with Interrupt Detection

A 32-pin general-purpose I/O port driven from a simple single-cycle register bus. Each pin is an input or an output. Output pins drive the value held in the data register. Input pins are sampled through a two-flop synchronizer, and software can read the synchronized value at any time.

Every pin has its own interrupt condition. The condition is one of four 2-bit modes, and a per-pin any-edge select bit overrides the mode. A detected condition sets a sticky status bit, which software clears by writing a 1 to it. Status bits that pass the mask are combined into two interrupt lines, one for pins 0 to 15 and one for pins 16 to 31.

Writes take effect at the clock edge where `reg_we` is high. Reads are combinational from `reg_addr`, which is a word index: byte offset divided by 4.

Top module: `gpio_irq_port`

## Requirements
- R1: Word index to register: 0 data, 1 direction, 2 pad status (read-only), 3 mode register for pins 0–15, 4 mode register for pins 16–31, 5 mask, 6 status, 7 any-edge select. Direction, mode, mask and any-edge select read back the value last written.
- R2: `pad_oe` equals the direction register, where bit 1 means output. `pad_out` equals the data register. Both change one clock after the write.
- R3: Pad status returns `pad_in` through two flops. A change driven before clock edge k shows up after edge k+1.
- R4: Reading the data register returns the written bit for output pins and the synchronized pad bit for input pins.
- R5: Mode codes are 0 low level, 1 high level, 2 rising edge, 3 falling edge. Pin p < 16 uses bits [2p+1:2p] of register 3. Pin p ≥ 16 uses bits [2(p−16)+1:2(p−16)] of register 4. For an edge, the status bit is set at the edge after the change reaches pad status.
- R6: When a pin's any-edge select bit is 1, both rising and falling edges set its status bit, whatever its mode.
- R7: Status bits stay set until a write to the status register with 1 in that bit position. Writing 0 leaves a bit unchanged.
- R8: In a level mode the status bit is set again on every cycle the level holds. A set and a clear in the same cycle leave the bit set.
- R9: `irq_lo` is the OR of status AND mask over bits 0–15. `irq_hi` is the same over bits 16–31.
- R10: Reset clears every register and the synchronizer to zero. All reads, `pad_oe`, `pad_out` and both interrupt lines are 0 while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register word index |
| reg_we | input | 1 | Write enable |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| pad_in | input | 32 | Pad input levels |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| irq_lo | output | 1 | Interrupt for pins 0–15 |
| irq_hi | output | 1 | Interrupt for pins 16–31 |

## Verification
The latencies are fixed:
- A register write is visible one edge later.
- A pad change reaches pad status and the data read two edges later.
- A pad change reaches the status bit, and through the mask an interrupt line, three edges later.

Inputs change only at the falling clock edge. A behavioural model advances at each rising edge, and all outputs are compared 2 ns after each falling edge, where every latency above has settled. Directed checks wait the exact number of edges and also sample one edge early where a result must not yet have appeared.

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int PINS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      reg_addr,
  input  logic            reg_we,
  input  logic [PINS-1:0] reg_wdata,
  output logic [PINS-1:0] reg_rdata,
  input  logic [PINS-1:0] pad_in,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_oe,
  output logic            irq_lo,
  output logic            irq_hi
);
  localparam int HALF = PINS / 2;

  localparam logic [2:0] A_DATA = 3'd0, A_DIR = 3'd1, A_PAD = 3'd2, A_MLO = 3'd3,
                         A_MHI = 3'd4, A_MASK = 3'd5, A_STAT = 3'd6, A_ANY = 3'd7;

  logic [PINS-1:0] data_q, dir_q, mlo_q, mhi_q, mask_q, stat_q, any_q;
  logic [PINS-1:0] sync1_q, sync2_q, prev_q;
  logic [PINS-1:0] hit;

  wire wr_stat = reg_we && reg_addr == A_STAT;
  wire [PINS-1:0] toggled = sync2_q ^ prev_q;

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    logic [1:0] mode;
    if (p < HALF) begin : g_lo
      assign mode = mlo_q[2*p +: 2];
    end else begin : g_hi
      assign mode = mhi_q[2*(p-HALF) +: 2];
    end
    always_comb begin
      if (any_q[p]) hit[p] = toggled[p];
      else case (mode)
        2'd0:    hit[p] = !sync2_q[p];
        2'd1:    hit[p] = sync2_q[p];
        2'd2:    hit[p] = sync2_q[p] && !prev_q[p];
        default: hit[p] = !sync2_q[p] && prev_q[p];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
      mlo_q  <= '0;
      mhi_q  <= '0;
      mask_q <= '0;
      any_q  <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_DATA: data_q <= reg_wdata;
        A_DIR:  dir_q  <= reg_wdata;
        A_MLO:  mlo_q  <= reg_wdata;
        A_MHI:  mhi_q  <= reg_wdata;
        A_MASK: mask_q <= reg_wdata;
        A_ANY:  any_q  <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~(wr_stat ? reg_wdata : '0)) | hit;
  end

  always_comb begin
    case (reg_addr)
      A_DATA:  reg_rdata = (data_q & dir_q) | (sync2_q & ~dir_q);
      A_DIR:   reg_rdata = dir_q;
      A_PAD:   reg_rdata = sync2_q;
      A_MLO:   reg_rdata = mlo_q;
      A_MHI:   reg_rdata = mhi_q;
      A_MASK:  reg_rdata = mask_q;
      A_STAT:  reg_rdata = stat_q;
      default: reg_rdata = any_q;
    endcase
  end

  wire [PINS-1:0] pending = stat_q & mask_q;
  assign irq_lo  = |pending[HALF-1:0];
  assign irq_hi  = |pending[PINS-1:HALF];
  assign pad_out = data_q;
  assign pad_oe  = dir_q;

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  a_r7_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> ((stat_q & $past(reg_wdata) & ~$past(hit)) == '0));

  a_r6_any_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (|(any_q & toggled)) |=> ((stat_q & $past(any_q & toggled)) == $past(any_q & toggled)));

  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q == '0) |-> (!irq_lo && !irq_hi));

  a_r2_oe_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == A_DIR) |=> $stable(pad_oe));
endmodule

// File: tb/test_gpio_irq_port.sv
module test_gpio_irq_port;
  logic clk = 0, rst_n = 0, reg_we = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, pad_in = 0;
  logic [31:0] reg_rdata, pad_out, pad_oe;
  logic irq_lo, irq_hi;
  int checks = 0, failures = 0;
  bit done = 0;

  gpio_irq_port i_gpio_irq_port (.clk, .rst_n, .reg_addr, .reg_we, .reg_wdata,
    .reg_rdata, .pad_in, .pad_out, .pad_oe, .irq_lo, .irq_hi);

  always #5 clk = ~clk;

  // behavioural reference model
  logic [31:0] m_reg [8];
  logic [31:0] m_s1 = 0, m_s2 = 0, m_pv = 0;
  initial for (int i = 0; i < 8; i++) m_reg[i] = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) m_reg[i] = 0;
      m_s1 = 0; m_s2 = 0; m_pv = 0;
    end else begin
      logic [31:0] setv, clr;
      setv = 0;
      for (int p = 0; p < 32; p++) begin
        int md;
        bit cur, old, h;
        md = p < 16 ? (m_reg[3] >> (2*p)) & 3 : (m_reg[4] >> (2*(p-16))) & 3;
        cur = m_s2[p]; old = m_pv[p];
        if (m_reg[7][p]) h = cur != old;
        else if (md == 0) h = !cur;
        else if (md == 1) h = cur;
        else if (md == 2) h = cur && !old;
        else h = !cur && old;
        setv[p] = h;
      end
      clr = (reg_we && reg_addr == 6) ? reg_wdata : 0;
      m_reg[6] = (m_reg[6] & ~clr) | setv;
      if (reg_we && reg_addr != 6 && reg_addr != 2) m_reg[reg_addr] = reg_wdata;
      m_pv = m_s2; m_s2 = m_s1; m_s1 = pad_in;
    end
  end

  function automatic logic [31:0] m_read(input logic [2:0] a);
    if (a == 0) return (m_reg[0] & m_reg[1]) | (m_s2 & ~m_reg[1]);
    if (a == 2) return m_s2;
    return m_reg[a];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #2;
    if (!done) begin
      check("R1 model rdata", reg_rdata, m_read(reg_addr));
      check("R2 model pad_out", pad_out, m_reg[0]);
      check("R2 model pad_oe", pad_oe, m_reg[1]);
      check("R9 model irq_lo", {31'd0, irq_lo}, {31'd0, |(m_reg[6][15:0] & m_reg[5][15:0])});
      check("R9 model irq_hi", {31'd0, irq_hi}, {31'd0, |(m_reg[6][31:16] & m_reg[5][31:16])});
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd_check(input string tag, input logic [2:0] a, input logic [31:0] exp);
    reg_addr = a; #2;
    check(tag, reg_rdata, exp);
  endtask

  initial begin
    // R10 reset state
    cyc(2);
    for (int a = 0; a < 8; a++) begin
      reg_addr = a[2:0]; #1;
      check("R10 reset read", reg_rdata, 0);
    end
    check("R10 reset oe", pad_oe, 0);
    check("R10 reset irq", {30'd0, irq_lo, irq_hi}, 0);
    @(negedge clk); rst_n = 1;

    // R2 / R1
    wr(1, 32'h0000_FFFF);
    wr(0, 32'hA5A5_1234);
    #2;
    check("R2 pad_oe", pad_oe, 32'h0000_FFFF);
    check("R2 pad_out", pad_out, 32'hA5A5_1234);
    rd_check("R1 dir readback", 1, 32'h0000_FFFF);

    // R3 sync latency
    @(negedge clk); pad_in = 32'h5A5A_00F0;
    @(negedge clk); rd_check("R3 pad not yet", 2, 0);
    @(negedge clk); rd_check("R3 pad arrived", 2, 32'h5A5A_00F0);
    rd_check("R4 data mix", 0, 32'h5A5A_1234);

    // R5 edge modes: pins 0-15 rising, pins 16-31 falling
    @(negedge clk); pad_in = 0;
    wr(1, 0);
    wr(3, 32'hAAAA_AAAA);
    wr(4, 32'hFFFF_FFFF);
    rd_check("R1 mode lo readback", 3, 32'hAAAA_AAAA);
    cyc(4);
    wr(6, 32'hFFFF_FFFF);
    rd_check("R7 cleared", 6, 0);
    @(negedge clk); pad_in = 32'h0001_0001;
    cyc(2); rd_check("R5 rise not yet", 6, 0);
    @(negedge clk); rd_check("R5 rising pin0 only", 6, 32'h0000_0001);
    @(negedge clk); pad_in = 0;
    cyc(3); rd_check("R5 falling pin16", 6, 32'h0001_0001);

    // R7 write-1 clears, 0 keeps
    wr(6, 32'h0000_0001);
    rd_check("R7 w1c", 6, 32'h0001_0000);
    wr(6, 32'h0000_0000);
    rd_check("R7 write0 keeps", 6, 32'h0001_0000);

    // R9 mask
    #2; check("R9 masked", {30'd0, irq_lo, irq_hi}, 0);
    wr(5, 32'h0001_0000);
    #2; check("R9 hi only", {30'd0, irq_lo, irq_hi}, 32'd1);
    wr(6, 32'h0001_0000);
    #2; check("R9 cleared", {30'd0, irq_lo, irq_hi}, 0);

    // R6 any-edge on pin 1 (mode rising)
    wr(7, 32'h0000_0002);
    @(negedge clk); pad_in = 32'h0000_0002;
    cyc(3); rd_check("R6 rise", 6, 32'h0000_0002);
    wr(6, 32'h0000_0002);
    @(negedge clk); pad_in = 0;
    cyc(3); rd_check("R6 fall", 6, 32'h0000_0002);
    wr(6, 32'hFFFF_FFFF);

    // R8 level high on pin 17 re-sets despite clear
    wr(4, 32'hFFFF_FFF7);
    @(negedge clk); pad_in = 32'h0002_0000;
    cyc(4);
    rd_check("R8 level set", 6, 32'h0002_0000);
    wr(6, 32'h0002_0000);
    rd_check("R8 set beats clear", 6, 32'h0002_0000);
    @(negedge clk); pad_in = 0;
    cyc(4);
    wr(6, 32'hFFFF_FFFF);
    rd_check("R8 level gone", 6, 0);

    // random traffic compared against the model
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      reg_we = ($urandom % 3) == 0;
      reg_addr = 3'($urandom);
      reg_wdata = $urandom;
      if (($urandom % 4) == 0) pad_in = $urandom;
    end
    @(negedge clk); reg_we = 0;
    cyc(3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule